// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block sits between a CPU bus and the serial shift engine of an SPI peripheral. It holds two small byte queues: a receive queue that the shift engine fills and the CPU drains, and a transmit queue that the CPU fills and the shift engine drains each time a transfer starts. It also builds a status word that the CPU reads. The status word gives the fill level of both queues, sticky error flags, per-direction interrupt flags and a summary interrupt, which also drives the `irq` pin.

Interrupts are raised after a programmed number of bytes. A mode input picks whether that count refers to bytes received or to bytes transmitted. Reading the status word clears every sticky flag. Two flush inputs empty the queues. While a flush input is held, the overflow or underflow event of the matching queue still records its flag but does not raise the summary interrupt.

Top module: `spi_fifo_stat`

## Requirements
- R1: Each queue holds up to DEPTH (default 4) bytes and returns them first in, first out. Its level is reported as a count from 0 to DEPTH. A write to a full transmit queue and a read from an empty receive queue are ignored.
- R2: A received byte that arrives while the receive queue is full is dropped, and the stored bytes are kept. The overflow flag is set at the same clock edge.
- R3: An overflow or underflow event sets the summary interrupt, unless the flush input of the matching queue is high in that cycle. The flag itself is set in either case.
- R4: A transfer start with an empty transmit queue sets the underflow flag. A transfer start with data pops the head byte, which is on `tx_data` before the start.
- R5: With `cfg_mode`=0, the receive interrupt flag sets on the accepted byte that brings the count of received bytes to N = `cfg_thresh`+1. The count then restarts. With `cfg_mode`=1, received bytes never set it.
- R6: With `cfg_mode`=1, the transmit interrupt flag sets on the transmitted byte that brings the count of popped bytes to N. The count then restarts.
- R7: The excess bit is high exactly while the receive level is greater than N.
- R8: A status read (`stat_rd`) clears the overflow, underflow, receive-interrupt, transmit-interrupt and summary flags at that clock edge. A flag whose set event happens in the same cycle stays set.
- R9: A flush input held at a clock edge empties its queue to level 0 and restarts that direction's byte count.
- R10: Status word layout, LSB first: [2:0] receive level, [5:3] transmit level, [6] excess, [7] overflow, [8] underflow, [9] receive interrupt, [10] transmit interrupt, [11] summary. `irq` equals bit 11.
- R11: After reset the status word is all zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Shift engine has a received byte |
| rx_data | input | 8 | Received byte |
| tx_start | input | 1 | Shift engine starts a transfer and takes the head byte |
| tx_data | output | 8 | Head of the transmit queue |
| cpu_wr | input | 1 | CPU write into the transmit queue |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rd | input | 1 | CPU pop from the receive queue |
| cpu_rdata | output | 8 | Head of the receive queue |
| stat_rd | input | 1 | CPU reads the status word (clears flags) |
| status | output | 12 | Status word, layout in R10 |
| irq | output | 1 | Summary interrupt |
| cfg_thresh | input | 2 | Byte count minus one for interrupts |
| cfg_mode | input | 1 | 0: count received bytes, 1: count transmitted bytes |
| rx_flush | input | 1 | Empty the receive queue |
| tx_flush | input | 1 | Empty the transmit queue |

## Verification
A corrupted level counter or pointer shows up one edge later. It appears either as a wrong level field or as a wrong byte on `cpu_rdata` or `tx_data` at the next pop. A byte-count register that drifts shows up as an interrupt flag that sets one byte early or one byte late. This is why every threshold is swept through a full fill and drain. A sticky flag that is lost or set wrongly is visible in the status word on the cycle right after the event or the read.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

  typedef enum logic {
    MODE_RX = 1'b0,
    MODE_TX = 1'b1
  } irq_mode_e;

  // Number of bytes that make one interrupt for a given threshold code.
  function automatic int bytes_needed(input int thresh_code);
    return thresh_code + 1;
  endfunction

  // Next fill level given accepted push / pop.
  function automatic int level_after(input int level, input logic push_ok,
                                     input logic pop_ok);
    return level + (push_ok ? 1 : 0) - (pop_ok ? 1 : 0);
  endfunction

  // Pointer advance that also works for non power of two depths.
  function automatic int ptr_advance(input int ptr, input int depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo
  import spi_fifo_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [LW-1:0] level,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          push_full,
  output logic          pop_empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic          full, empty;

  assign full      = (level == LW'(DEPTH));
  assign empty     = (level == '0);
  assign push_ok   = push && !full && !flush;
  assign pop_ok    = pop && !empty && !flush;
  assign push_full = push && full;
  assign pop_empty = pop && empty;
  assign head      = mem[rptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push_ok) begin
        mem[wptr] <= push_data;
        wptr      <= PW'(ptr_advance(int'(wptr), DEPTH));
      end
      if (pop_ok) rptr <= PW'(ptr_advance(int'(rptr), DEPTH));
      level <= LW'(level_after(int'(level), push_ok, pop_ok));
    end
  end

  a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  a_r2_full_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    push && full && !pop && !flush |=> level == LW'(DEPTH) && $stable(head));

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> level == '0);

endmodule

// File: rtl/spi_xfer_count.sv
module spi_xfer_count #(
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          event_i,
  input  logic [LW-1:0] need,
  output logic          hit
);
  logic [LW-1:0] cnt;
  logic [LW-1:0] cnt_inc;

  assign cnt_inc = cnt + LW'(1);
  assign hit     = event_i && !clear && (cnt_inc >= need);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clear)   cnt <= '0;
    else if (event_i) cnt <= hit ? '0 : cnt_inc;
  end

  a_r5_count_below_need: assert property (@(posedge clk) disable iff (!rst_n)
    $past(event_i) && !$past(clear) && $stable(need) |-> cnt < need);

endmodule

// File: rtl/spi_stat_flags.sv
module spi_stat_flags #(
  parameter int NF = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_clear,
  input  logic [NF-1:0] set,
  output logic [NF-1:0] flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (rd_clear ? '0 : flags) | set;
  end

  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clear && set == '0 |=> flags == '0);

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set != '0 |=> (flags & $past(set)) == $past(set));

endmodule

// File: rtl/spi_fifo_stat.sv
module spi_fifo_stat
  import spi_fifo_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  parameter int LW    = $clog2(DEPTH + 1),
  parameter int TW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int SW    = 2 * LW + 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          tx_start,
  output logic [DW-1:0] tx_data,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          cpu_rd,
  output logic [DW-1:0] cpu_rdata,
  input  logic          stat_rd,
  output logic [SW-1:0] status,
  output logic          irq,
  input  logic [TW-1:0] cfg_thresh,
  input  logic          cfg_mode,
  input  logic          rx_flush,
  input  logic          tx_flush
);
  localparam int NF    = 5;
  localparam int F_OVF = 0;
  localparam int F_UNF = 1;
  localparam int F_RXI = 2;
  localparam int F_TXI = 3;
  localparam int F_SUM = 4;

  // Named internal events
  logic [LW-1:0] rx_level, tx_level, need;
  logic          rx_push_ok, rx_pop_ok, ovf_ev, rx_pop_empty;
  logic          tx_push_ok, tx_pop_ok, tx_push_full, unf_ev;
  logic          rx_hit, tx_hit, sum_ev, excess;
  logic          rx_cnt_clear, tx_cnt_clear;
  logic [NF-1:0] flag_set, flags;
  irq_mode_e     mode;

  assign mode = irq_mode_e'(cfg_mode);
  assign need = LW'(bytes_needed(int'(cfg_thresh)));

  spi_byte_fifo #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) u_rx_fifo (
    .clk, .rst_n,
    .flush     (rx_flush),
    .push      (rx_valid),
    .push_data (rx_data),
    .pop       (cpu_rd),
    .head      (cpu_rdata),
    .level     (rx_level),
    .push_ok   (rx_push_ok),
    .pop_ok    (rx_pop_ok),
    .push_full (ovf_ev),
    .pop_empty (rx_pop_empty)
  );

  spi_byte_fifo #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) u_tx_fifo (
    .clk, .rst_n,
    .flush     (tx_flush),
    .push      (cpu_wr),
    .push_data (cpu_wdata),
    .pop       (tx_start),
    .head      (tx_data),
    .level     (tx_level),
    .push_ok   (tx_push_ok),
    .pop_ok    (tx_pop_ok),
    .push_full (tx_push_full),
    .pop_empty (unf_ev)
  );

  assign rx_cnt_clear = rx_flush || (mode != MODE_RX);
  assign tx_cnt_clear = tx_flush || (mode != MODE_TX);

  spi_xfer_count #(.LW(LW)) u_rx_count (
    .clk, .rst_n,
    .clear   (rx_cnt_clear),
    .event_i (rx_push_ok),
    .need    (need),
    .hit     (rx_hit)
  );

  spi_xfer_count #(.LW(LW)) u_tx_count (
    .clk, .rst_n,
    .clear   (tx_cnt_clear),
    .event_i (tx_pop_ok),
    .need    (need),
    .hit     (tx_hit)
  );

  assign sum_ev = (ovf_ev && !rx_flush) || (unf_ev && !tx_flush) || rx_hit || tx_hit;

  always_comb begin
    flag_set        = '0;
    flag_set[F_OVF] = ovf_ev;
    flag_set[F_UNF] = unf_ev;
    flag_set[F_RXI] = rx_hit;
    flag_set[F_TXI] = tx_hit;
    flag_set[F_SUM] = sum_ev;
  end

  spi_stat_flags #(.NF(NF)) u_flags (
    .clk, .rst_n,
    .rd_clear (stat_rd),
    .set      (flag_set),
    .flags    (flags)
  );

  assign excess = rx_level > need;
  assign status = {flags[F_SUM], flags[F_TXI], flags[F_RXI], flags[F_UNF],
                   flags[F_OVF], excess, tx_level, rx_level};
  assign irq    = flags[F_SUM];

  a_r3_ovf_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev && !rx_flush |=> irq);

  a_r4_underflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start && tx_level == '0 |=> status[2*LW+2]);

  a_r5_rx_irq_mode: assert property (@(posedge clk) disable iff (!rst_n)
    rx_hit |-> mode == MODE_RX);

  a_r6_tx_irq_mode: assert property (@(posedge clk) disable iff (!rst_n)
    tx_hit |-> mode == MODE_TX);

  a_r1_no_ignored_pop: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop_empty && !rx_valid && !rx_flush |=> rx_level == '0);

  a_r1_full_write_drop: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push_full && !tx_start && !tx_flush |=> tx_level == LW'(DEPTH));

endmodule

// File: tb/spi_fifo_stat_bench.sv
module spi_fifo_stat_bench;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_valid, tx_start, cpu_wr, cpu_rd, stat_rd;
  logic        cfg_mode, rx_flush, tx_flush;
  logic [7:0]  rx_data, cpu_wdata, tx_data, cpu_rdata;
  logic [1:0]  cfg_thresh;
  logic [11:0] status;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  spi_fifo_stat u_spi_fifo_stat (
    .clk, .rst_n, .rx_valid, .rx_data, .tx_start, .tx_data, .cpu_wr,
    .cpu_wdata, .cpu_rd, .cpu_rdata, .stat_rd, .status, .irq,
    .cfg_thresh, .cfg_mode, .rx_flush, .tx_flush
  );

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push_rx(input logic [7:0] d);
    rx_valid = 1'b1; rx_data = d; tick(); rx_valid = 1'b0;
  endtask
  task automatic read_stat();
    stat_rd = 1'b1; tick(); stat_rd = 1'b0;
  endtask
  task automatic flush_both();
    rx_flush = 1'b1; tx_flush = 1'b1; tick(); rx_flush = 1'b0; tx_flush = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rx_valid = 0; tx_start = 0; cpu_wr = 0; cpu_rd = 0; stat_rd = 0;
    cfg_mode = 0; rx_flush = 0; tx_flush = 0; rx_data = 0; cpu_wdata = 0;
    cfg_thresh = 0;
    repeat (3) tick();
    check("R11 reset status", int'(status), 0);
    check("R11 reset irq", int'(irq), 0);
    rst_n = 1'b1;
    tick();

    // Receive direction, every threshold, fill past full then drain
    for (int thr = 0; thr < 4; thr++) begin
      cfg_mode = 1'b0; cfg_thresh = 2'(thr);
      flush_both(); read_stat();
      check("R8 cleared before sweep", int'(status), 0);
      for (int i = 1; i <= 5; i++) begin
        int lvl;
        bit rxi, ovf;
        push_rx(8'(thr * 16 + i));
        lvl = (i < DEPTH) ? i : DEPTH;
        rxi = (i >= thr + 1);
        ovf = (i == 5);
        check("R1 rx level", int'(status[2:0]), lvl);
        check("R7 excess", int'(status[6]), int'(lvl > thr + 1));
        check("R5 rx irq", int'(status[9]), int'(rxi));
        check("R2 overflow flag", int'(status[7]), int'(ovf));
        check("R3 summary", int'(status[11]), int'(rxi | ovf));
        check("R10 irq pin", int'(irq), int'(status[11]));
      end
      for (int i = 1; i <= 4; i++) begin
        check("R2 kept byte order", int'(cpu_rdata), thr * 16 + i);
        cpu_rd = 1'b1; tick(); cpu_rd = 1'b0;
        check("R1 rx level after pop", int'(status[2:0]), 4 - i);
        check("R7 excess after pop", int'(status[6]), int'((4 - i) > thr + 1));
      end
      cpu_rd = 1'b1; tick(); cpu_rd = 1'b0;
      check("R1 empty pop ignored", int'(status[2:0]), 0);
    end

    // Read clear versus simultaneous overflow (threshold 3)
    cfg_mode = 1'b0; cfg_thresh = 2'd3;
    flush_both(); read_stat();
    for (int i = 0; i < 4; i++) push_rx(8'(i));
    check("R5 rx irq at four", int'(status[9]), 1);
    rx_valid = 1'b1; stat_rd = 1'b1; tick(); rx_valid = 1'b0; stat_rd = 1'b0;
    check("R8 set wins ovf", int'(status[7]), 1);
    check("R8 read clears rx irq", int'(status[9]), 0);
    check("R8 set wins summary", int'(status[11]), 1);
    read_stat();
    check("R8 read clears all flags", int'(status[11:7]), 0);
    check("R8 level untouched by read", int'(status[2:0]), 4);

    // Overflow while flushing: flag set, summary suppressed, queue emptied
    rx_valid = 1'b1; rx_flush = 1'b1; tick(); rx_valid = 1'b0; rx_flush = 1'b0;
    check("R9 rx flush level", int'(status[2:0]), 0);
    check("R3 ovf flag under flush", int'(status[7]), 1);
    check("R3 summary suppressed rx", int'(irq), 0);
    // Flush restarted the count: three more bytes then no irq, fourth irq
    for (int i = 1; i <= 4; i++) begin
      push_rx(8'(i));
      check("R9 count restart", int'(status[9]), int'(i == 4));
    end

    // Transmit direction, every threshold
    for (int thr = 0; thr < 4; thr++) begin
      cfg_mode = 1'b1; cfg_thresh = 2'(thr);
      flush_both(); read_stat();
      for (int j = 0; j < 5; j++) begin
        cpu_wr = 1'b1; cpu_wdata = 8'(8'hA0 + thr * 8 + j); tick(); cpu_wr = 1'b0;
      end
      check("R1 tx level full, fifth write dropped", int'(status[5:3]), 4);
      for (int s = 1; s <= 5; s++) begin
        int lvl;
        bit txi, unf;
        if (s <= 4) check("R4 tx head byte", int'(tx_data), 8'hA0 + thr * 8 + s - 1);
        tx_start = 1'b1; tick(); tx_start = 1'b0;
        lvl = (4 - s > 0) ? 4 - s : 0;
        txi = (s >= thr + 1);
        unf = (s == 5);
        check("R1 tx level", int'(status[5:3]), lvl);
        check("R6 tx irq", int'(status[10]), int'(txi));
        check("R4 underflow", int'(status[8]), int'(unf));
        check("R3 summary tx", int'(irq), int'(txi | unf));
      end
    end

    // Received bytes never raise rx irq in transmit mode
    cfg_mode = 1'b1; cfg_thresh = 2'd0;
    flush_both(); read_stat();
    push_rx(8'h55);
    check("R5 no rx irq in tx mode", int'(status[9]), 0);
    check("R5 no summary in tx mode", int'(irq), 0);

    // Underflow while flushing transmit queue
    read_stat();
    tx_start = 1'b1; tx_flush = 1'b1; tick(); tx_start = 1'b0; tx_flush = 1'b0;
    check("R3 unf flag under flush", int'(status[8]), 1);
    check("R3 summary suppressed tx", int'(irq), 0);
    check("R9 rx untouched by tx flush", int'(status[2:0]), 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule